// File: doc/BRIEF.md
# Register-Pair Signed Divide Unit

This execution unit divides a signed 64-bit dividend, held across an even/odd register pair, by a signed 32-bit divisor. The caller presents both halves of the pair, the number of the first-operand register, and two candidate divisors: one read from a register and one fetched as a fullword from storage. A select input picks between them. After a start pulse the unit works on magnitudes, one quotient bit per cycle, then applies the signs. It returns a 32-bit quotient for the odd register and a 32-bit remainder for the even register, with a write enable.

The unit raises a divide exception when the divisor is zero or when the signed quotient does not fit in 32 bits. It raises a specification exception when the first-operand register number is odd. When either exception is raised, no write is requested and the original pair values are presented unchanged on the result outputs. Register file access, storage access and condition codes belong to the surrounding pipeline.

Top module: `pair_divider`

## Requirements
- R1: The dividend is `{pair_even_in, pair_odd_in}`, with the even register as the high 32 bits. The divisor is `dsr_reg_in` when `dsr_sel` is 0 and `dsr_word_in` when `dsr_sel` is 1. The unselected divisor has no effect on any result.
- R2: On a successful divide, `done` and `wr_en` are high together for one cycle. `odd_out` carries the quotient and `even_out` carries the remainder.
- R3: The quotient truncates toward zero and is negative exactly when the operand signs differ. A nonzero remainder takes the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R4: A zero divisor raises `div_exc` with `done`.
- R5: An odd `reg_num` raises `spec_exc` with `done`, and in that case `div_exc` stays low even if the divisor is zero.
- R6: `div_exc` is raised when the true signed quotient lies outside -2^31 to 2^31-1. This covers both a high half whose magnitude is at least the divisor magnitude and a quotient magnitude of exactly 2^31 that is positive. A quotient of exactly -2^31 is delivered normally.
- R7: When either exception is raised, `wr_en` stays low, and `even_out`/`odd_out` show the original pair halves.
- R8: If start is sampled at edge E, an exception detected before iterating gives `done` after edge E+1. A full divide, including one that ends in a post-iteration overflow, gives `done` after edge E+34. `busy` is high between start and `done`, is low while `done` is high, and `done` lasts one cycle.
- R9: A start pulse while `busy` is high is ignored. The running operation completes with its own operands and timing.
- R10: After reset, `done`, `wr_en`, `busy`, `div_exc` and `spec_exc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| reg_num | input | 4 | First-operand register number (must be even) |
| pair_even_in | input | 32 | Even register: dividend high half |
| pair_odd_in | input | 32 | Odd register: dividend low half |
| dsr_sel | input | 1 | Divisor source: 0 register, 1 fullword |
| dsr_reg_in | input | 32 | Divisor from a register |
| dsr_word_in | input | 32 | Divisor fullword from storage |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Write the pair with the results |
| even_out | output | 32 | Remainder, or original even half on exception |
| odd_out | output | 32 | Quotient, or original odd half on exception |
| div_exc | output | 1 | Divide exception (with done) |
| spec_exc | output | 1 | Specification exception (with done) |

## Verification
Results fall on one of two fixed schedules. An exception found during operand preparation completes one edge after the start edge. A full divide, whether it ends in results or in a late overflow, completes 34 edges after it. Each operation in the bench counts falling edges from the start edge until `done` and compares that count with the schedule expected for the vector. All outputs are read on that same falling edge, away from the rising edge that updates them. A second start is also injected mid-run, and the bench confirms that neither the count nor the results move.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREP,
        ST_ITER,
        ST_FIX
    } pdiv_state_e;
endpackage

// File: rtl/pdiv_mag.sv
// Sign and magnitude of a two's complement value.
module pdiv_mag #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] val,
    output logic         neg,
    output logic [W-1:0] mag
);
    always_comb begin
        neg = val[W-1];
        mag = neg ? (~val + 1'b1) : val;
    end
endmodule

// File: rtl/pdiv_step.sv
// One restoring division step: shift in a dividend bit, trial-subtract.
module pdiv_step #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] rem,
    input  logic         in_bit,
    input  logic [W-1:0] dsr,
    output logic [W-1:0] rem_nxt,
    output logic         q_bit
);
    logic [W:0] trial;
    logic [W:0] diff;

    always_comb begin
        trial   = {rem, in_bit};
        diff    = trial - {1'b0, dsr};
        q_bit   = (trial >= {1'b0, dsr});
        rem_nxt = q_bit ? diff[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/pdiv_fix.sv
// Apply result signs and detect a quotient outside the signed range.
module pdiv_fix #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         q_neg,
    input  logic         r_neg,
    output logic [W-1:0] q,
    output logic [W-1:0] r,
    output logic         ovf
);
    localparam logic [W-1:0] MIN_MAG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        ovf = q_neg ? (q_mag > MIN_MAG) : q_mag[W-1];
        q   = q_neg ? (~q_mag + 1'b1) : q_mag;
        r   = r_neg ? (~r_mag + 1'b1) : r_mag;
    end
endmodule

// File: rtl/pair_divider.sv
module pair_divider
    import pdiv_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned RNUMW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RNUMW-1:0] reg_num,
    input  logic [XLEN-1:0]  pair_even_in,
    input  logic [XLEN-1:0]  pair_odd_in,
    input  logic             dsr_sel,
    input  logic [XLEN-1:0]  dsr_reg_in,
    input  logic [XLEN-1:0]  dsr_word_in,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [XLEN-1:0]  even_out,
    output logic [XLEN-1:0]  odd_out,
    output logic             div_exc,
    output logic             spec_exc
);
    localparam int unsigned DLEN = 2 * XLEN;
    localparam int unsigned CW   = $clog2(XLEN);
    localparam logic [CW-1:0] LAST = CW'(XLEN - 1);

    typedef struct packed {
        pdiv_state_e      st;
        logic [XLEN-1:0]  even;
        logic [XLEN-1:0]  odd;
        logic [XLEN-1:0]  dsr;
        logic             rn_odd;
        logic [XLEN-1:0]  rem;
        logic [XLEN-1:0]  quo;
        logic [XLEN-1:0]  dmag;
        logic             dvd_neg;
        logic             dsr_neg;
        logic [CW-1:0]    cnt;
        logic             done;
        logic             wr;
        logic             dexc;
        logic             sexc;
        logic [XLEN-1:0]  even_o;
        logic [XLEN-1:0]  odd_o;
    } pdiv_regs_t;

    pdiv_regs_t r_d, r_q;

    logic            dvd_neg_w, dsr_neg_w, q_bit_w, ovf_w;
    logic [DLEN-1:0] dvd_mag_w;
    logic [XLEN-1:0] dsr_mag_w, rem_nxt_w, q_fix_w, r_fix_w;

    pdiv_mag #(.W(DLEN)) i_dvd_mag (
        .val ({r_q.even, r_q.odd}),
        .neg (dvd_neg_w),
        .mag (dvd_mag_w)
    );

    pdiv_mag #(.W(XLEN)) i_dsr_mag (
        .val (r_q.dsr),
        .neg (dsr_neg_w),
        .mag (dsr_mag_w)
    );

    pdiv_step #(.W(XLEN)) i_step (
        .rem     (r_q.rem),
        .in_bit  (r_q.quo[XLEN-1]),
        .dsr     (r_q.dmag),
        .rem_nxt (rem_nxt_w),
        .q_bit   (q_bit_w)
    );

    pdiv_fix #(.W(XLEN)) i_fix (
        .q_mag (r_q.quo),
        .r_mag (r_q.rem),
        .q_neg (r_q.dvd_neg ^ r_q.dsr_neg),
        .r_neg (r_q.dvd_neg),
        .q     (q_fix_w),
        .r     (r_fix_w),
        .ovf   (ovf_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.wr   = 1'b0;
        r_d.dexc = 1'b0;
        r_d.sexc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_PREP;
                    r_d.even   = pair_even_in;
                    r_d.odd    = pair_odd_in;
                    r_d.dsr    = dsr_sel ? dsr_word_in : dsr_reg_in;
                    r_d.rn_odd = reg_num[0];
                end
            end
            ST_PREP: begin
                r_d.rem     = dvd_mag_w[DLEN-1:XLEN];
                r_d.quo     = dvd_mag_w[XLEN-1:0];
                r_d.dmag    = dsr_mag_w;
                r_d.dvd_neg = dvd_neg_w;
                r_d.dsr_neg = dsr_neg_w;
                r_d.cnt     = '0;
                if (r_q.rn_odd || (r_q.dsr == '0) ||
                    (dvd_mag_w[DLEN-1:XLEN] >= dsr_mag_w)) begin
                    r_d.st     = ST_IDLE;
                    r_d.done   = 1'b1;
                    r_d.sexc   = r_q.rn_odd;
                    r_d.dexc   = !r_q.rn_odd;
                    r_d.even_o = r_q.even;
                    r_d.odd_o  = r_q.odd;
                end else begin
                    r_d.st = ST_ITER;
                end
            end
            ST_ITER: begin
                r_d.rem = rem_nxt_w;
                r_d.quo = {r_q.quo[XLEN-2:0], q_bit_w};
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                if (ovf_w) begin
                    r_d.dexc   = 1'b1;
                    r_d.even_o = r_q.even;
                    r_d.odd_o  = r_q.odd;
                end else begin
                    r_d.wr     = 1'b1;
                    r_d.even_o = r_fix_w;
                    r_d.odd_o  = q_fix_w;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign wr_en    = r_q.wr;
    assign even_out = r_q.even_o;
    assign odd_out  = r_q.odd_o;
    assign div_exc  = r_q.dexc;
    assign spec_exc = r_q.sexc;

    AST_EXC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_exc || spec_exc) |-> !wr_en); // R7
    AST_EXC_KEEPS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (div_exc || spec_exc) |-> (even_out == r_q.even && odd_out == r_q.odd)); // R7
    AST_ONE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div_exc, spec_exc})); // R5
    AST_SPEC_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        spec_exc |-> r_q.rn_odd); // R5
    AST_ZERO_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.dsr == '0 && !r_q.rn_odd) |-> div_exc); // R4
    AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && even_out != '0) |-> (even_out[XLEN-1] == r_q.dvd_neg)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.even) && $stable(r_q.odd) && $stable(r_q.dsr))); // R9
endmodule

// File: tb/test_pair_divider.sv
`timescale 1ns/1ps
module test_pair_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  reg_num = '0;
    logic [31:0] pair_even_in = '0, pair_odd_in = '0;
    logic        dsr_sel = 1'b0;
    logic [31:0] dsr_reg_in = '0, dsr_word_in = '0;
    logic        busy, done, wr_en, div_exc, spec_exc;
    logic [31:0] even_out, odd_out;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pair_divider i_pair_divider (
        .clk, .rst_n, .start, .reg_num, .pair_even_in, .pair_odd_in,
        .dsr_sel, .dsr_reg_in, .dsr_word_in, .busy, .done, .wr_en,
        .even_out, .odd_out, .div_exc, .spec_exc
    );

    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] dsr;
        logic [3:0]  rn;
        logic        src;
        logic [31:0] x_even;
        logic [31:0] x_odd;
        logic        x_div;
        logic        x_spec;
        logic [5:0]  x_cyc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0, 32'd100, 32'd7, 4'd2, 1'b0, 32'd2, 32'd14, 1'b0, 1'b0, 6'd34},
        '{32'hFFFFFFFF, 32'hFFFFFF9C, 32'd7, 4'd2, 1'b1, 32'hFFFFFFFE, 32'hFFFFFFF2, 1'b0, 1'b0, 6'd34},
        '{32'h0, 32'd100, 32'hFFFFFFF9, 4'd4, 1'b0, 32'd2, 32'hFFFFFFF2, 1'b0, 1'b0, 6'd34},
        '{32'hFFFFFFFF, 32'hFFFFFF9C, 32'hFFFFFFF9, 4'd6, 1'b1, 32'hFFFFFFFE, 32'd14, 1'b0, 1'b0, 6'd34},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'd3, 4'd0, 1'b0, 32'hFFFFFFFF, 32'd0, 1'b0, 1'b0, 6'd34},
        '{32'h0, 32'hFFFFFFFF, 32'h10, 4'd8, 1'b0, 32'hF, 32'h0FFFFFFF, 1'b0, 1'b0, 6'd34},
        '{32'h1, 32'h0, 32'h7FFFFFFF, 4'd10, 1'b1, 32'd2, 32'd2, 1'b0, 1'b0, 6'd34},
        '{32'hFFFFFFFF, 32'h0, 32'd2, 4'd12, 1'b0, 32'd0, 32'h80000000, 1'b0, 1'b0, 6'd34},
        '{32'h1, 32'h0, 32'd2, 4'd14, 1'b0, 32'h1, 32'h0, 1'b1, 1'b0, 6'd34},
        '{32'hFFFFFFFF, 32'h0, 32'hFFFFFFFE, 4'd2, 1'b1, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 6'd34},
        '{32'h5, 32'h0, 32'd3, 4'd4, 1'b0, 32'h5, 32'h0, 1'b1, 1'b0, 6'd1},
        '{32'h0, 32'd64, 32'd0, 4'd6, 1'b0, 32'h0, 32'd64, 1'b1, 1'b0, 6'd1},
        '{32'h0, 32'd64, 32'd0, 4'd3, 1'b0, 32'h0, 32'd64, 1'b0, 1'b1, 6'd1},
        '{32'h80000000, 32'h0, 32'hFFFFFFFF, 4'd0, 1'b0, 32'h80000000, 32'h0, 1'b1, 1'b0, 6'd1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx, input bit poke);
        int cyc;
        @(negedge clk);
        pair_even_in = v.hi;
        pair_odd_in  = v.lo;
        reg_num      = v.rn;
        dsr_sel      = v.src;
        dsr_reg_in   = v.src ? ~v.dsr : v.dsr;   // R1: unselected source differs
        dsr_word_in  = v.src ? v.dsr : ~v.dsr;
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        do begin
            if (poke && cyc == 5) begin
                pair_even_in = 32'h0;
                pair_odd_in  = 32'd64;
                dsr_reg_in   = 32'd0;
                dsr_word_in  = 32'd0;
                reg_num      = 4'd3;
                start        = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc == 10 && v.x_cyc > 6'd10)
                chk(busy === 1'b1, "R8", $sformatf("busy mid-run vec%0d", idx), 64'(busy), 64'd1);
        end while (done !== 1'b1 && cyc < 100);
        chk(cyc == int'(v.x_cyc), poke ? "R9" : "R8", $sformatf("done latency vec%0d", idx),
            64'(cyc), 64'(v.x_cyc));
        chk(busy === 1'b0, "R8", $sformatf("busy low at done vec%0d", idx), 64'(busy), 64'd0);
        chk(div_exc === v.x_div, v.x_div ? "R4/R6" : "R6", $sformatf("div_exc vec%0d", idx),
            64'(div_exc), 64'(v.x_div));
        chk(spec_exc === v.x_spec, "R5", $sformatf("spec_exc vec%0d", idx), 64'(spec_exc), 64'(v.x_spec));
        chk(wr_en === !(v.x_div || v.x_spec), (v.x_div || v.x_spec) ? "R7" : "R2",
            $sformatf("wr_en vec%0d", idx), 64'(wr_en), 64'(!(v.x_div || v.x_spec)));
        chk({even_out, odd_out} === {v.x_even, v.x_odd}, (v.x_div || v.x_spec) ? "R7" : "R3",
            $sformatf("pair results vec%0d", idx), {even_out, odd_out}, {v.x_even, v.x_odd});
        @(negedge clk);
        chk(done === 1'b0, "R8", $sformatf("done one cycle vec%0d", idx), 64'(done), 64'd0);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({done, wr_en, busy, div_exc, spec_exc} === 5'b0, "R10", "outputs in reset",
            64'({done, wr_en, busy, div_exc, spec_exc}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({done, wr_en, busy, div_exc, spec_exc} === 5'b0, "R10", "outputs after reset",
            64'({done, wr_en, busy, div_exc, spec_exc}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i, 1'b0);
        end

        // R9: second start mid-run (odd register, zero divisor) must be ignored
        run_vec(VECS[0], 100, 1'b1);
        run_vec(VECS[3], 103, 1'b1);

        // R1: same divide with divisor taken from the other source
        begin
            vec_t v = VECS[5];
            v.src = 1'b1;
            run_vec(v, 105, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule